// File: doc/BRIEF.md
# Burst-threshold transfer gate

This block is the control half of a memory-facing DMA channel. It keeps a count of the double-words that have been buffered for transfer and raises a memory burst request only once that count reaches a limit set by software. Until then, data stays in the buffer. The effect is that memory traffic is issued in full bursts of a tuned size, not as a trickle of short transactions.

Software programs the limit through a small register port with separate read and write strobes. The programmed limit reads back from the control register. A separate read-only status register reports the largest burst the channel supports. A request carries a length and stays raised until memory grants it. Only one request is outstanding at any time. When the stream ends, whatever is still buffered is sent as one or more final bursts, the last of which may be short.

Top module: `burst_gate`

## Requirements
- R1: After reset the burst request is low, and both the control register (select 0) and the status register (select 1) read back MAX_WORDS (16).
- R2: A write to select 0 stores the written value as the limit, with two exceptions: 0 is stored as 1, and any value above MAX_WORDS is stored as MAX_WORDS. The stored value reads back from select 0.
- R3: Select 1 always reads MAX_WORDS, and writes to select 1 have no effect on either register.
- R4: While the buffered count is below the limit and no end of stream is pending, no request is raised.
- R5: When the buffered count is at or above the current limit and no request is outstanding, a request is raised with a length equal to the limit.
- R6: A raised request holds its length unchanged until the cycle in which the grant is high.
- R7: A grant during a request drops the request on the next cycle and subtracts the length from the count. A push in that same cycle is still counted.
- R8: After an end-of-stream pulse, the buffered words are sent in bursts of at most the limit. The last burst carries the remainder. A pulse that arrives when nothing is buffered causes no request.
- R9: The count never exceeds MAX_WORDS. A push that arrives while the count is at MAX_WORDS is dropped.
- R10: A grant while no request is raised has no effect on the count.
- R11: Read data appears in the cycle after the read strobe. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | DATA_W (8) | Write data |
| reg_rdata | output | DATA_W (8) | Registered read data |
| dw_push | input | 1 | One double-word was buffered this cycle |
| eos | input | 1 | End-of-stream pulse |
| burst_req | output | 1 | Burst request to memory |
| burst_len | output | CNT_W (5) | Length of the requested burst |
| burst_gnt | input | 1 | Memory accepts the current request |

## Verification
The hardest case to reach is a full buffer that keeps receiving pushes while a request waits unanswered. In that state dropped words and a flush longer than the limit both become visible. The bench can stall its memory responder on demand. It holds a request open while it pushes past MAX_WORDS, or while it pushes more than one burst's worth and pulses end of stream. It then releases the grant and checks the exact sequence of lengths that follows. A grant outside any request is injected between pushes, so that a decrement applied without a request would show up as a wrong or unexpected burst.

// File: rtl/burst_gate_pkg.sv
package burst_gate_pkg;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/burst_gate_regs.sv
module burst_gate_regs
    import burst_gate_pkg::*;
#(
    parameter int MAX_WORDS = 16,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  limit
);

    localparam logic [DATA_W-1:0] MAX_D = DATA_W'(MAX_WORDS);
    localparam logic [CNT_W-1:0]  MAX_C = CNT_W'(MAX_WORDS);

    typedef struct packed {
        logic [CNT_W-1:0]  limit;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;

    function automatic logic [CNT_W-1:0] clamp(input logic [DATA_W-1:0] v);
        if (v == '0)
            return CNT_W'(1);
        else if (v > MAX_D)
            return MAX_C;
        else
            return CNT_W'(v);
    endfunction

    always_comb begin
        st_d = st_q;
        if (rd) begin
            if (reg_sel_e'(sel) == SEL_STAT)
                st_d.rdata = MAX_D;
            else
                st_d.rdata = DATA_W'(st_q.limit);
        end
        if (wr && reg_sel_e'(sel) == SEL_CTRL)
            st_d.limit = clamp(wdata);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.limit <= MAX_C;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign limit = st_q.limit;

endmodule

// File: rtl/burst_gate_count.sv
module burst_gate_count #(
    parameter int MAX_WORDS = 16,
    parameter int CNT_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             take,
    input  logic [CNT_W-1:0] take_len,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_WORDS);

    typedef struct packed {
        logic [CNT_W-1:0] fill;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push && st_q.fill < MAX_C)
            st_d.fill = st_d.fill + CNT_W'(1);
        if (take)
            st_d.fill = st_d.fill - take_len;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q.fill <= '0;
        else
            st_q <= st_d;
    end

    assign count = st_q.fill;

endmodule

// File: rtl/burst_gate_issue.sv
module burst_gate_issue #(
    parameter int MAX_WORDS = 16,
    parameter int CNT_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] limit,
    input  logic             eos,
    input  logic             gnt,
    output logic             req,
    output logic [CNT_W-1:0] len,
    output logic             take
);

    typedef struct packed {
        logic             req;
        logic [CNT_W-1:0] len;
        logic             flush;
    } iss_t;

    iss_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flush = st_q.flush | eos;
        if (st_q.req) begin
            if (gnt)
                st_d.req = 1'b0;
        end else if (count >= limit) begin
            st_d.req = 1'b1;
            st_d.len = limit;
        end else if (st_q.flush && count != '0) begin
            st_d.req = 1'b1;
            st_d.len = count;
        end else if (count == '0) begin
            st_d.flush = eos;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.req   <= 1'b0;
            st_q.len   <= '0;
            st_q.flush <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req  = st_q.req;
    assign len  = st_q.len;
    assign take = st_q.req & gnt;

endmodule

// File: rtl/burst_gate.sv
module burst_gate #(
    parameter int MAX_WORDS = 16,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dw_push,
    input  logic              eos,
    output logic              burst_req,
    output logic [$clog2(MAX_WORDS+1)-1:0] burst_len,
    input  logic              burst_gnt
);

    localparam int CNT_W = $clog2(MAX_WORDS + 1);

    logic [CNT_W-1:0] limit_w;
    logic [CNT_W-1:0] cnt_w;
    logic             take_w;

    burst_gate_regs #(
        .MAX_WORDS(MAX_WORDS), .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .sel(reg_sel),
        .wdata(reg_wdata), .rdata(reg_rdata), .limit(limit_w)
    );

    burst_gate_count #(
        .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)
    ) u_count (
        .clk(clk), .rst_n(rst_n), .push(dw_push), .take(take_w),
        .take_len(burst_len), .count(cnt_w)
    );

    burst_gate_issue #(
        .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)
    ) u_issue (
        .clk(clk), .rst_n(rst_n), .count(cnt_w), .limit(limit_w), .eos(eos),
        .gnt(burst_gnt), .req(burst_req), .len(burst_len), .take(take_w)
    );

endmodule

// File: rtl/burst_gate_chk.sv
module burst_gate_chk #(
    parameter int MAX_WORDS = 16,
    parameter int CNT_W     = $clog2(MAX_WORDS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic             gnt,
    input logic [CNT_W-1:0] len,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] limit
);

    a_r6_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !gnt) |=> (req && $stable(len)));

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (req && gnt) |=> !req);

    a_r5_len_covered: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (len != '0 && len <= cnt));

    a_r4_len_from_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> ($past(cnt) >= len));

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAX_WORDS));

    a_r2_limit_range: assert property (@(posedge clk) disable iff (!rst_n)
        (limit != '0 && limit <= CNT_W'(MAX_WORDS)));

endmodule

bind burst_gate burst_gate_chk #(
    .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req(burst_req), .gnt(burst_gnt),
    .len(burst_len), .cnt(cnt_w), .limit(limit_w)
);

// File: tb/burst_gate_test.sv
`timescale 1ns/1ps
module burst_gate_test;

    localparam int MAXW = 16;
    localparam int DW   = 8;
    localparam int CW   = $clog2(MAXW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          dw_push = 1'b0, eos = 1'b0;
    logic          burst_req;
    logic [CW-1:0] burst_len;
    logic          mon_gnt = 1'b0, drv_gnt = 1'b0, mon_hold = 1'b0;
    logic          burst_gnt;

    int    errors = 0, checks = 0, hold_ctr = 0;
    bit    done = 0;
    int    exp_q[$];
    string tag_q[$];

    assign burst_gnt = mon_gnt | drv_gnt;

    always #2 clk = ~clk;

    burst_gate #(.MAX_WORDS(MAXW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dw_push(dw_push), .eos(eos), .burst_req(burst_req),
        .burst_len(burst_len), .burst_gnt(burst_gnt)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic wr(input bit sel, input int val);
        reg_sel = sel; reg_wdata = DW'(val); reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input bit sel, input int exp, input string tag);
        reg_sel = sel; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        check(reg_rdata == DW'(exp), tag, reg_rdata, exp);
    endtask

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) begin
            dw_push = 1'b1;
            @(negedge clk);
        end
        dw_push = 1'b0;
    endtask

    task automatic pulse_eos();
        eos = 1'b1;
        @(negedge clk);
        eos = 1'b0;
    endtask

    task automatic expect_burst(input int len, input string tag);
        exp_q.push_back(len);
        tag_q.push_back(tag);
    endtask

    task automatic settle(input int n, input string tag);
        repeat (n) @(negedge clk);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    // Monitor: pops expected lengths as requests appear, then grants.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && burst_req) begin
                int    e;
                string t;
                int    h;
                if (exp_q.size() == 0) begin
                    e = -1; t = "R4 unexpected burst";
                end else begin
                    e = exp_q.pop_front(); t = tag_q.pop_front();
                end
                check(int'(burst_len) == e, t, burst_len, e);
                h = hold_ctr % 3;
                hold_ctr++;
                for (int i = 0; i < h; i++) begin
                    @(negedge clk);
                    check(burst_req && int'(burst_len) == e, "R6", burst_len, e);
                end
                while (mon_hold) begin
                    @(negedge clk);
                    check(burst_req && int'(burst_len) == e, "R6", burst_len, e);
                end
                mon_gnt = 1'b1;
                @(negedge clk);
                mon_gnt = 1'b0;
                check(!burst_req, "R7 drop after grant", burst_req, 0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(!burst_req, "R1 req", burst_req, 0);
        rd_check(1'b0, MAXW, "R1 ctrl");
        rd_check(1'b1, MAXW, "R1 status");

        // R2 clamp and R3 status read-only
        wr(1'b0, 4);   rd_check(1'b0, 4, "R2 plain");
        wr(1'b0, 0);   rd_check(1'b0, 1, "R2 zero");
        wr(1'b0, 200); rd_check(1'b0, MAXW, "R2 over");
        wr(1'b1, 3);
        rd_check(1'b1, MAXW, "R3 status");
        rd_check(1'b0, MAXW, "R3 ctrl untouched");

        // R4 hold below limit, R5 issue at limit
        wr(1'b0, 4);
        push_n(3);
        repeat (5) @(negedge clk);
        check(!burst_req, "R4 held", burst_req, 0);
        expect_burst(4, "R5 at limit");
        push_n(1);
        settle(10, "R5 done");

        // R7 grants during a continuous push stream, then R8 short flush
        expect_burst(4, "R7 first");
        expect_burst(4, "R7 second");
        push_n(10);
        settle(12, "R7 done");
        check(!burst_req, "R4 remainder held", burst_req, 0);
        expect_burst(2, "R8 short flush");
        pulse_eos();
        settle(10, "R8 done");

        // R9 pushes beyond a full buffer are dropped
        mon_hold = 1'b1;
        wr(1'b0, 16);
        expect_burst(16, "R9 full");
        push_n(18);
        repeat (3) @(negedge clk);
        mon_hold = 1'b0;
        settle(10, "R9 full done");
        pulse_eos();
        settle(8, "R9 nothing left");

        // R10 stray grant ignored
        wr(1'b0, 3);
        push_n(2);
        drv_gnt = 1'b1;
        @(negedge clk);
        drv_gnt = 1'b0;
        expect_burst(3, "R10 count intact");
        push_n(1);
        settle(10, "R10 done");
        pulse_eos();
        settle(8, "R10 nothing left");

        // R8 flush larger than the limit splits
        wr(1'b0, 4);
        mon_hold = 1'b1;
        expect_burst(4, "R8 split first");
        expect_burst(2, "R8 split rest");
        push_n(6);
        pulse_eos();
        repeat (2) @(negedge clk);
        mon_hold = 1'b0;
        settle(12, "R8 split done");

        // R11 read and write in the same cycle
        reg_sel = 1'b0; reg_wdata = DW'(7); reg_wr = 1'b1; reg_rd = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        check(reg_rdata == DW'(4), "R11 old value", reg_rdata, 4);
        rd_check(1'b0, 7, "R11 new value");

        // R5 lowering the limit below the buffered count issues at once
        push_n(5);
        repeat (3) @(negedge clk);
        check(!burst_req, "R4 below 7", burst_req, 0);
        expect_burst(4, "R5 lowered limit");
        wr(1'b0, 4);
        settle(10, "R5 lowered done");
        expect_burst(1, "R8 single word");
        pulse_eos();
        settle(10, "R8 single done");

        finish_run();
    end

endmodule